// File: doc/BRIEF.md
# Three-Level Translation Table Walker with Indirect Page Descriptors

The walker turns a 32-bit logical address into a physical address by reading descriptors from memory. It starts from a root pointer and reads one descriptor at each of three levels: root, pointer and page. If the page-level descriptor is an indirect one, it makes one more read through the pointer that descriptor holds. It then returns either the physical address or an access error with a cause code.

A requester places the logical address, the root pointer and the access kind on the request port. The access kind says whether the access is a read or a write, and whether it is a data operand or an instruction fetch. The walker issues descriptor reads one at a time over a valid/ready request channel. Each read is answered by a single response beat.

Write protection is collected along the path the walk takes. An operand fault is reported with the completion pulse. A fault on an instruction fetch is held back until the fetched instruction is actually used.

Top module: `xlat_walker`

## Requirements
- R1: The logical address splits, from the top down, into a 7-bit root index (bits 31:25), a 7-bit pointer index (bits 24:18), a 6-bit page index (bits 17:12) and a 12-bit offset. Each entry address is formed as follows:
  - The root entry is at {req_root[31:9], root index, 00}. The low 9 bits of req_root are ignored.
  - The pointer entry is at {root descriptor[31:9], pointer index, 00}.
  - The page entry is at {pointer descriptor[31:8], page index, 00}.
- R2: A normal walk makes exactly three reads. A resident page descriptor has type bits [1:0] of 01 or 11. For such a descriptor, paddr is {descriptor[31:12], logical offset}, and done pulses high for exactly one cycle.
- R3: A page descriptor of type 10 is indirect. The walker makes a fourth read at {descriptor[31:2], 00}. The physical frame is then taken from the descriptor returned by that fourth read.
- R4: A descriptor reached through an indirect pointer that is itself of type 10 ends the walk with cause 3 (chained indirection) after four reads.
- R5: A root or pointer descriptor whose bit 1 is clear (type 00 or 01) ends the walk at that level with cause 1, and no further read is made. All other bits of such a descriptor have no effect.
- R6: A page descriptor of type 00 ends the walk with cause 2. This applies whether it is reached directly or through an indirect pointer.
- R7: Bit 2 is the write-protect bit. It is taken from the root, pointer and final page descriptors and ORed together; the indirect descriptor itself contributes none. A write through a protected mapping ends with cause 4. A read through the same mapping completes normally.
- R8: For an operand access, fault rises together with done, and fault_cause holds the cause: 1 invalid table, 2 invalid page, 3 chained indirection, 4 write protect.
- R9: For an instruction fetch that faults, done pulses with fault low. The walker then stays busy (req_ready low) until ifetch_use is sampled high. In the next cycle fault rises with the recorded cause, and the walker becomes ready again.
- R10: Only one walk is in flight. req_ready is high only when the walker is idle. A descriptor read request stays asserted with a stable address until it is accepted.
- R11: After reset, req_ready is high, and done, fault and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Root table pointer |
| req_write | input | 1 | Access is a write |
| req_ifetch | input | 1 | Access is an instruction fetch |
| ifetch_use | input | 1 | Held fetch result is being consumed |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data beat present |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access error reported |
| fault_cause | output | 3 | Error cause code |
| paddr | output | 32 | Physical address on success |

## Verification
The walker is driven with addresses that end at each kind of descriptor:
- a resident page descriptor;
- an indirect pointer to a resident page descriptor;
- an indirect pointer to an invalid page descriptor;
- an indirect pointer to another indirect descriptor;
- an invalid descriptor at the root, pointer and page levels.

The number of reads in each walk separates an early stop from a walk that reads too much, and the returned frame shows which descriptor supplied the mapping.

The same mappings are walked once as reads and once as writes, with the protect bit placed at the root, at the pointer level or at the page level. This shows that the protect bits are collected across the levels and that only writes are refused.

Instruction-fetch walks, run on both faulting and clean mappings, separate the held-back report from the immediate one. A root pointer with its low bits set confirms that the entry addresses take their index bits from the logical address and ignore those low bits.

// File: rtl/xw_pkg.sv
// Shared types for the translation walker: walk level, page descriptor
// kind and fault cause codes. Cause code values are visible at the top port.
package xw_pkg;
    typedef enum logic [1:0] {
        LV_ROOT  = 2'd0,
        LV_PTR   = 2'd1,
        LV_PAGE  = 2'd2,
        LV_INDIR = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        PK_INVALID  = 2'd0,
        PK_RESIDENT = 2'd1,
        PK_INDIRECT = 2'd2
    } pkind_e;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_BAD_TABLE = 3'd1,
        FC_BAD_PAGE  = 3'd2,
        FC_CHAINED   = 3'd3,
        FC_WPROT     = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } wstate_e;
endpackage

// File: rtl/xw_addr_gen.sv
// Forms the byte address of the next descriptor read from the current
// level. Assumes every table is aligned to its own size, so each entry
// address is a concatenation of the base, the index and two zero bits.
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PAGE_OFF_W = 12
) (
    input  level_e                                   level,
    input  logic [ADDR_W-1:ROOT_IDX_W+2]             root_hi,
    input  logic [ADDR_W-1:0]                        tbl_base,
    input  logic [ADDR_W-1:0]                        laddr,
    input  logic [ADDR_W-1:0]                        indir_ptr,
    output logic [ADDR_W-1:0]                        fetch_addr
);
    localparam int PAGE_IDX_W = ADDR_W - ROOT_IDX_W - PTR_IDX_W - PAGE_OFF_W;
    localparam int ROOT_LSB   = ADDR_W - ROOT_IDX_W;
    localparam int PTR_LSB    = ROOT_LSB - PTR_IDX_W;
    localparam int PTR_ALIGN  = PTR_IDX_W + 2;
    localparam int PAGE_ALIGN = PAGE_IDX_W + 2;

    logic [ROOT_IDX_W-1:0] root_idx;
    logic [PTR_IDX_W-1:0]  ptr_idx;
    logic [PAGE_IDX_W-1:0] page_idx;

    assign root_idx = laddr[ADDR_W-1:ROOT_LSB];
    assign ptr_idx  = laddr[ROOT_LSB-1:PTR_LSB];
    assign page_idx = laddr[PTR_LSB-1:PAGE_OFF_W];

    // Select the entry address for the level being fetched.
    always_comb begin
        unique case (level)
            LV_ROOT:  fetch_addr = {root_hi, root_idx, 2'b00};
            LV_PTR:   fetch_addr = {tbl_base[ADDR_W-1:PTR_ALIGN], ptr_idx, 2'b00};
            LV_PAGE:  fetch_addr = {tbl_base[ADDR_W-1:PAGE_ALIGN], page_idx, 2'b00};
            default:  fetch_addr = indir_ptr;
        endcase
    end
endmodule

// File: rtl/xw_desc_decode.sv
// Decodes one descriptor word. Only the type bits, the write-protect bit
// and the address fields are looked at; all other bits pass through unused.
module xw_desc_decode
    import xw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFF_W = 12
) (
    input  logic [ADDR_W-1:0]            desc,
    output logic                         tbl_valid,
    output logic                         wp_bit,
    output pkind_e                       page_kind,
    output logic [ADDR_W-1:PAGE_OFF_W]   frame,
    output logic [ADDR_W-1:0]            indir_ptr
);
    assign tbl_valid = desc[1];
    assign wp_bit    = desc[2];
    assign frame     = desc[ADDR_W-1:PAGE_OFF_W];
    assign indir_ptr = {desc[ADDR_W-1:2], 2'b00};

    // Classify a page-level descriptor from its two type bits.
    always_comb begin
        unique case (desc[1:0])
            2'b00:   page_kind = PK_INVALID;
            2'b10:   page_kind = PK_INDIRECT;
            default: page_kind = PK_RESIDENT;
        endcase
    end
endmodule

// File: rtl/xw_fault_hold.sv
// Keeps a fault raised by an instruction-fetch walk until the fetch is
// used. Assumes a new capture only happens when nothing is pending.
module xw_fault_hold
    import xw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture,
    input  cause_e cause_in,
    input  logic   use_strobe,
    output logic   pending,
    output logic   fire,
    output cause_e cause_out
);
    assign fire = pending && use_strobe;

    // Set on capture, clear when the held result is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            cause_out <= FC_NONE;
        end else if (capture) begin
            pending   <= 1'b1;
            cause_out <= cause_in;
        end else if (fire) begin
            pending   <= 1'b0;
        end
    end

    a_r9_no_double_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !pending);
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !pending);
endmodule

// File: rtl/xlat_walker.sv
// Three-level translation table walker. Accepts one request while idle,
// reads root, pointer and page descriptors over a valid/ready port with a
// single response beat per read, follows one indirect page descriptor,
// ORs protect bits and reports a physical address or a fault cause.
// Assumes the memory answers each accepted read with exactly one beat.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PAGE_OFF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic [ADDR_W-1:0] req_root,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic              ifetch_use,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_cause,
    output logic [ADDR_W-1:0] paddr
);
    localparam int ROOT_ALIGN = ROOT_IDX_W + 2;

    wstate_e                     state_q;
    level_e                      level_q;
    logic [ADDR_W-1:0]           laddr_q;
    logic [ADDR_W-1:ROOT_ALIGN]  root_hi_q;
    logic [ADDR_W-1:0]           tbl_base_q;
    logic [ADDR_W-1:0]           indir_q;
    logic                        write_q;
    logic                        ifetch_q;
    logic                        wp_q;
    logic                        done_q;
    logic                        fault_q;
    cause_e                      cause_q;
    logic [ADDR_W-1:0]           paddr_q;

    logic                        tbl_valid;
    logic                        wp_bit;
    pkind_e                      page_kind;
    logic [ADDR_W-1:PAGE_OFF_W]  frame;
    logic [ADDR_W-1:0]           dec_indir;

    logic                        fin;
    cause_e                      fin_cause;
    level_e                      nxt_level;
    logic                        wp_nxt;
    logic                        rsp_take;
    logic                        hold_capture;
    logic                        hold_pending;
    logic                        hold_fire;
    cause_e                      hold_cause;

    xw_addr_gen #(
        .ADDR_W(ADDR_W), .ROOT_IDX_W(ROOT_IDX_W),
        .PTR_IDX_W(PTR_IDX_W), .PAGE_OFF_W(PAGE_OFF_W)
    ) u_addr (
        .level(level_q), .root_hi(root_hi_q), .tbl_base(tbl_base_q),
        .laddr(laddr_q), .indir_ptr(indir_q), .fetch_addr(mem_req_addr)
    );

    xw_desc_decode #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W)) u_dec (
        .desc(mem_rsp_data), .tbl_valid(tbl_valid), .wp_bit(wp_bit),
        .page_kind(page_kind), .frame(frame), .indir_ptr(dec_indir)
    );

    xw_fault_hold u_hold (
        .clk(clk), .rst_n(rst_n), .capture(hold_capture), .cause_in(fin_cause),
        .use_strobe(ifetch_use), .pending(hold_pending), .fire(hold_fire),
        .cause_out(hold_cause)
    );

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign rsp_take      = (state_q == ST_WAIT) && mem_rsp_valid;
    assign hold_capture  = rsp_take && fin && (fin_cause != FC_NONE) && ifetch_q;
    assign done          = done_q;
    assign fault         = fault_q;
    assign fault_cause   = cause_q;
    assign paddr         = paddr_q;

    // Decide what the descriptor arriving now means for the walk.
    always_comb begin
        fin       = 1'b0;
        fin_cause = FC_NONE;
        nxt_level = level_q;
        wp_nxt    = wp_q;
        unique case (level_q)
            LV_ROOT, LV_PTR: begin
                if (!tbl_valid) begin
                    fin       = 1'b1;
                    fin_cause = FC_BAD_TABLE;
                end else begin
                    wp_nxt    = wp_q | wp_bit;
                    nxt_level = (level_q == LV_ROOT) ? LV_PTR : LV_PAGE;
                end
            end
            default: begin
                if (page_kind == PK_INVALID) begin
                    fin       = 1'b1;
                    fin_cause = FC_BAD_PAGE;
                end else if (page_kind == PK_INDIRECT) begin
                    if (level_q == LV_INDIR) begin
                        fin       = 1'b1;
                        fin_cause = FC_CHAINED;
                    end else begin
                        nxt_level = LV_INDIR;
                    end
                end else begin
                    fin    = 1'b1;
                    wp_nxt = wp_q | wp_bit;
                    if (write_q && wp_nxt) fin_cause = FC_WPROT;
                end
            end
        endcase
    end

    // Walk sequencer and registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            level_q    <= LV_ROOT;
            laddr_q    <= '0;
            root_hi_q  <= '0;
            tbl_base_q <= '0;
            indir_q    <= '0;
            write_q    <= 1'b0;
            ifetch_q   <= 1'b0;
            wp_q       <= 1'b0;
            done_q     <= 1'b0;
            fault_q    <= 1'b0;
            cause_q    <= FC_NONE;
            paddr_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            cause_q <= FC_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        laddr_q   <= req_laddr;
                        root_hi_q <= req_root[ADDR_W-1:ROOT_ALIGN];
                        write_q   <= req_write;
                        ifetch_q  <= req_ifetch;
                        wp_q      <= 1'b0;
                        level_q   <= LV_ROOT;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        wp_q <= wp_nxt;
                        if (!fin) begin
                            level_q    <= nxt_level;
                            tbl_base_q <= mem_rsp_data;
                            indir_q    <= dec_indir;
                            state_q    <= ST_ISSUE;
                        end else begin
                            done_q <= 1'b1;
                            if (fin_cause == FC_NONE) begin
                                paddr_q <= {frame, laddr_q[PAGE_OFF_W-1:0]};
                                state_q <= ST_IDLE;
                            end else if (ifetch_q) begin
                                paddr_q <= '0;
                                state_q <= ST_HOLD;
                            end else begin
                                paddr_q <= '0;
                                fault_q <= 1'b1;
                                cause_q <= fin_cause;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                end
                default: begin
                    if (hold_fire) begin
                        fault_q <= 1'b1;
                        cause_q <= hold_cause;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    a_r10_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid && !req_ready);
    a_r8_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done || $past(ifetch_use));
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_cause_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_cause != 3'd0);
    a_r9_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold_pending |-> !fault && !req_ready);
endmodule

// File: tb/xlat_walker_tb.sv
// Self-checking bench: a behavioural descriptor memory, a vector table of
// walks, then directed reset, addressing and instruction-fetch tests.
module xlat_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic [31:0] req_root = '0;
    logic        req_write = 1'b0;
    logic        req_ifetch = 1'b0;
    logic        ifetch_use = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [2:0]  fault_cause;
    logic [31:0] paddr;

    int n_checks = 0;
    int n_fails  = 0;
    int fetch_cnt = 0;
    logic [31:0] fa [0:7];
    logic [31:0] mem [0:1023];
    logic        rsp_due = 1'b0;
    logic [31:0] rsp_addr = '0;

    always #2 clk = ~clk;

    xlat_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_root(req_root), .req_write(req_write),
        .req_ifetch(req_ifetch), .ifetch_use(ifetch_use),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_cause(fault_cause), .paddr(paddr)
    );

    // Behavioural memory: answers each accepted read one cycle later.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_due) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[rsp_addr[11:2]];
            rsp_due       = 1'b0;
        end else if (mem_req_valid) begin
            rsp_due  = 1'b1;
            rsp_addr = mem_req_addr;
            if (fetch_cnt < 8) fa[fetch_cnt] = mem_req_addr;
            fetch_cnt++;
        end
    end

    function automatic logic [31:0] la(int r, int p, int g, int o);
        return {r[6:0], p[6:0], g[5:0], o[11:0]};
    endfunction

    typedef struct packed {
        logic [31:0] laddr;
        logic        wr;
        logic [2:0]  cause;
        logic [31:0] pa;
        logic [3:0]  nf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{la(0,0,0,'h123), 1'b0, 3'd0, 32'h1234_5123, 4'd3, 4'd2},  // R2 normal
        '{la(0,0,1,'hABC), 1'b0, 3'd0, 32'h0F00_DABC, 4'd4, 4'd3},  // R3 indirect
        '{la(0,0,2,0),     1'b0, 3'd3, 32'h0,         4'd4, 4'd4},  // R4 chained
        '{la(1,0,0,0),     1'b0, 3'd1, 32'h0,         4'd1, 4'd5},  // R5 root type 00
        '{la(0,1,0,0),     1'b0, 3'd1, 32'h0,         4'd2, 4'd5},  // R5 pointer type 01
        '{la(3,0,0,0),     1'b0, 3'd1, 32'h0,         4'd1, 4'd5},  // R5 junk bits set
        '{la(0,0,3,0),     1'b0, 3'd2, 32'h0,         4'd3, 4'd6},  // R6 direct
        '{la(0,0,5,0),     1'b0, 3'd2, 32'h0,         4'd4, 4'd6},  // R6 via indirect
        '{la(0,2,0,'h10),  1'b1, 3'd4, 32'h0,         4'd3, 4'd7},  // R7 pointer W
        '{la(0,2,0,'h10),  1'b0, 3'd0, 32'h1234_5010, 4'd3, 4'd7},  // R7 read ok
        '{la(2,0,0,0),     1'b1, 3'd4, 32'h0,         4'd3, 4'd7},  // R7 root W
        '{la(0,0,4,'h7FF), 1'b1, 3'd4, 32'h0,         4'd3, 4'd7},  // R7 page W
        '{la(0,0,4,'h7FF), 1'b0, 3'd0, 32'hABCD_E7FF, 4'd3, 4'd7},  // R7 read ok
        '{la(0,0,0,'h456), 1'b1, 3'd0, 32'h1234_5456, 4'd3, 4'd7}   // R7 write ok
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] a, input logic [31:0] root,
                        input logic wr, input logic ifv, output logic busy_seen);
        @(negedge clk);
        fetch_cnt  = 0;
        req_laddr  = a;
        req_root   = root;
        req_write  = wr;
        req_ifetch = ifv;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        busy_seen  = !req_ready;
        for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[0]     = 32'h0000_0202;
        mem[1]     = 32'h0000_5554;
        mem[2]     = 32'h0000_0206;
        mem[3]     = 32'hFFFF_FFFD;
        mem['h80]  = 32'h0000_0402;
        mem['h81]  = 32'h0000_0001;
        mem['h82]  = 32'h0000_0406;
        mem['h100] = 32'h1234_5001;
        mem['h101] = 32'h0000_0802;
        mem['h102] = 32'h0000_0806;
        mem['h103] = 32'h0000_0000;
        mem['h104] = 32'hABCD_E007;
        mem['h105] = 32'h0000_080E;
        mem['h200] = 32'h0F00_D001;
        mem['h201] = 32'h0000_0812;
        mem['h203] = 32'h0000_0000;
    end

    initial begin
        logic busy;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready === 1'b1, "R11 ready", {31'd0, req_ready}, 32'd1);
        chk(done === 1'b0 && fault === 1'b0, "R11 done/fault", {30'd0, done, fault}, 32'd0);
        chk(mem_req_valid === 1'b0, "R11 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            walk(VECS[v].laddr, 32'h0, VECS[v].wr, 1'b0, busy);
            if (v == 0) chk(busy, "R10 busy during walk", {31'd0, busy}, 32'd1);
            chk(done === 1'b1, $sformatf("R%0d row %0d done", VECS[v].req, v),
                {31'd0, done}, 32'd1);
            // R8: operand faults arrive together with done
            chk(fault === (VECS[v].cause != 3'd0),
                $sformatf("R8/R%0d row %0d fault", VECS[v].req, v),
                {31'd0, fault}, {31'd0, VECS[v].cause != 3'd0});
            chk(fault_cause === VECS[v].cause,
                $sformatf("R%0d row %0d cause", VECS[v].req, v),
                {29'd0, fault_cause}, {29'd0, VECS[v].cause});
            if (VECS[v].cause == 3'd0)
                chk(paddr === VECS[v].pa, $sformatf("R%0d row %0d paddr", VECS[v].req, v),
                    paddr, VECS[v].pa);
            chk(fetch_cnt == int'(VECS[v].nf),
                $sformatf("R%0d row %0d reads", VECS[v].req, v),
                fetch_cnt, {28'd0, VECS[v].nf});
            @(negedge clk);
            chk(done === 1'b0, "R2 done pulse width", {31'd0, done}, 32'd0);
        end

        // R1 entry addresses, low root bits ignored
        walk(la(0,0,1,'hABC), 32'h0000_01FC, 1'b0, 1'b0, busy);
        chk(fa[0] === 32'h0, "R1 root entry", fa[0], 32'h0);
        chk(fa[1] === 32'h200, "R1 pointer entry", fa[1], 32'h200);
        chk(fa[2] === 32'h404, "R1 page entry", fa[2], 32'h404);
        chk(fa[3] === 32'h800, "R3 indirect target", fa[3], 32'h800);
        walk(la(3,5,0,0), 32'h0, 1'b0, 1'b0, busy);
        chk(fa[0] === 32'hC, "R1 root index", fa[0], 32'hC);

        // R9 deferred instruction-fetch fault
        walk(la(1,0,0,0), 32'h0, 1'b0, 1'b1, busy);
        chk(done === 1'b1 && fault === 1'b0, "R9 done without fault",
            {30'd0, done, fault}, 32'd2);
        repeat (3) @(negedge clk);
        chk(fault === 1'b0 && req_ready === 1'b0, "R9 held busy",
            {30'd0, fault, req_ready}, 32'd0);
        ifetch_use = 1'b1;
        @(negedge clk);
        ifetch_use = 1'b0;
        chk(fault === 1'b1, "R9 fault after use", {31'd0, fault}, 32'd1);
        chk(fault_cause === 3'd1, "R9 cause", {29'd0, fault_cause}, 32'd1);
        @(negedge clk);
        chk(req_ready === 1'b1 && fault === 1'b0, "R9 ready again",
            {30'd0, req_ready, fault}, 32'd2);

        // R9 clean instruction fetch completes at once
        walk(la(0,0,0,5), 32'h0, 1'b0, 1'b1, busy);
        chk(done === 1'b1 && fault === 1'b0 && paddr === 32'h1234_5005,
            "R9 clean fetch", paddr, 32'h1234_5005);
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 clean fetch not held", {31'd0, req_ready}, 32'd1);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired R10 actual %h expected %h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule